// File: doc/BRIEF.md
# Per-Line Lamp Pulse Controller

This block produces the red, green and blue illumination enables for a line-scanning image sensor. A free-running pixel counter counts from zero up to a programmable line-end value and then starts over. The span from zero to line end is one line period. Each colour has its own turn-on and turn-off pixel position. Its lamp output is switched against the running count, so the light pulse repeats at the same place in every line it belongs to.

The block has two modes. In sequential mode each line belongs to a single colour, and the lines rotate red, green, blue, red. In all-colours mode every lamp pulses in every line. The counter and the lamp pulses keep running whenever standby is low, whether or not a scan is in progress, so the light sources stay warm. A scan-sync strobe marks the lines on which a new scan may begin. In sequential mode that is every red line; in all-colours mode it is every line. While standby is high the counter sits at zero and all lamps are dark. When standby is released, the colour sequence starts again at red.

Top module: `lamp_pulse_ctrl`

## Requirements
- R1: After reset, and after standby is released, the first cycle at pixel 0 raises `line_start`. `line_start` is then high for exactly one cycle in every `line_end`+1 cycles, always at pixel 0. When the count is at or above `line_end`, the next pixel is 0.
- R2: In sequential mode (`mode_all`=0), `color_idx` is 0 for red, 1 for green and 2 for blue. It is 0 on the first line after standby or reset and advances 0, 1, 2, 0 at each line start. It never takes the value 3.
- R3: The lamp of an active colour is high from the cycle whose pixel equals its `on_pos` value. It is low from the cycle whose pixel equals its `off_pos` value. If both values are equal, turn-on wins.
- R4: A colour whose `on_pos` is greater than `line_end` never lights.
- R5: A colour whose `off_pos` is greater than `line_end` stays on once lit. In all-colours mode it stays on permanently. In sequential mode it stays on until its own line ends.
- R6: In sequential mode, only the lamp of the colour in `color_idx` can be high. Lamp bit 0 is red, bit 1 is green and bit 2 is blue.
- R7: In all-colours mode (`mode_all`=1), all three lamps follow their own positions in every line, and `color_idx` stays 0.
- R8: `scan_sync` is high only together with `line_start`. It is high on red lines in sequential mode and on every line start in all-colours mode.
- R9: One clock edge after `standby` is sampled high, all lamps are low, `line_start` and `scan_sync` are low, and `color_idx` is 0. They stay that way until standby is released.
- R10: While reset is asserted, all lamps, `line_start` and `scan_sync` are low and `color_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Stops the counter and darkens all lamps |
| mode_all | input | 1 | 0: one colour per line, 1: all colours every line |
| line_end | input | PIX_W | Last pixel index of a line |
| on_pos | input | 3 x PIX_W | Turn-on pixel per colour (index 0 red, 1 green, 2 blue) |
| off_pos | input | 3 x PIX_W | Turn-off pixel per colour |
| lamp | output | 3 | Lamp enables (bit 0 red, 1 green, 2 blue) |
| line_start | output | 1 | One-cycle strobe at pixel 0 |
| scan_sync | output | 1 | Line start on which a scan may begin |
| color_idx | output | 2 | Colour owning the current line |

## Verification
Three events can land on the same edge: a lamp switch, the counter wrap, and the colour hand-over in sequential mode. The bench provokes this in several ways. It places a turn-on at the line-end pixel, sets a turn-on at pixel 0 of the next colour, and programs equal on and off positions. It then compares every lamp, strobe and colour output, cycle by cycle, against an expectation built from pixel and line numbers counted since standby release. From these cases the bench judges three things: a lamp lit on the last pixel is dropped exactly when its line hands over, a lamp set for pixel 0 is already high in the line-start cycle, and turn-on beats turn-off when both match.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    localparam int NUM_COL = 3;

    typedef enum logic [1:0] {
        COL_RED   = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2
    } color_e;

    function automatic color_e color_after(input color_e cur);
        case (cur)
            COL_RED:   return COL_GREEN;
            COL_GREEN: return COL_BLUE;
            default:   return COL_RED;
        endcase
    endfunction

endpackage

// File: rtl/lpc_pixel_counter.sv
module lpc_pixel_counter #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic [PIX_W-1:0] line_end,
    output logic [PIX_W-1:0] cnt_q_o,
    output logic [PIX_W-1:0] cnt_d_o,
    output logic             run_q_o,
    output logic             run_d_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic             run;
        logic [PIX_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d     = st_q;
        st_d.run = !standby;
        wrap     = st_q.run && (st_q.cnt >= line_end);
        if (!st_d.run || !st_q.run || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;
    assign run_q_o = st_q.run;
    assign run_d_o = st_d.run;
    assign wrap_o  = wrap;

    // R1: a count at or past the line end is followed by pixel 0
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.cnt >= line_end) |=> (st_q.cnt == '0));

    // R1: inside a running line the count steps by one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !standby && st_q.cnt < line_end) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R9: standby holds the count at zero
    a_r9_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (st_q.cnt == '0 && !st_q.run));

endmodule

// File: rtl/lpc_color_seq.sv
module lpc_color_seq
    import lamp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_d,
    input  logic   wrap,
    input  logic   mode_all,
    output color_e col_q_o,
    output color_e col_d_o
);

    typedef struct packed {
        color_e col;
    } col_state_t;

    col_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_d || mode_all) begin
            st_d.col = COL_RED;
        end else if (wrap) begin
            st_d.col = color_after(st_q.col);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{col: COL_RED};
        end else begin
            st_q <= st_d;
        end
    end

    assign col_q_o = st_q.col;
    assign col_d_o = st_d.col;

    // R2: the colour index never leaves the three legal codes
    a_r2_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.col != color_e'(2'd3));

    // R2: without a wrap the colour is kept
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_d && !mode_all && !wrap) |=> $stable(st_q.col));

    // R7: all-colours mode pins the index to red
    a_r7_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode_all |=> (st_q.col == COL_RED));

endmodule

// File: rtl/lpc_lamp_chan.sv
module lpc_lamp_chan #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_nxt,
    input  logic [PIX_W-1:0] cnt_nxt,
    input  logic [PIX_W-1:0] on_at,
    input  logic [PIX_W-1:0] off_at,
    output logic             lamp_o
);

    typedef struct packed {
        logic lit;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_nxt) begin
            st_d.lit = 1'b0;
        end else if (cnt_nxt == on_at) begin
            st_d.lit = 1'b1;
        end else if (cnt_nxt == off_at) begin
            st_d.lit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lamp_o = st_q.lit;

    // R3: reaching the turn-on pixel lights the lamp
    a_r3_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (active_nxt && cnt_nxt == on_at) |=> lamp_o);

    // R3: reaching the turn-off pixel (without a turn-on match) darkens it
    a_r3_turn_off: assert property (@(posedge clk) disable iff (!rst_n)
        (active_nxt && cnt_nxt == off_at && cnt_nxt != on_at) |=> !lamp_o);

    // R3: away from both points the lamp keeps its level
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active_nxt && cnt_nxt != off_at && cnt_nxt != on_at) |=> $stable(lamp_o));

endmodule

// File: rtl/lamp_pulse_ctrl.sv
module lamp_pulse_ctrl
    import lamp_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            standby,
    input  logic                            mode_all,
    input  logic [PIX_W-1:0]                line_end,
    input  logic [NUM_COL-1:0][PIX_W-1:0]   on_pos,
    input  logic [NUM_COL-1:0][PIX_W-1:0]   off_pos,
    output logic [NUM_COL-1:0]              lamp,
    output logic                            line_start,
    output logic                            scan_sync,
    output logic [1:0]                      color_idx
);

    logic [PIX_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d, wrap;
    color_e           col_q, col_d;

    lpc_pixel_counter #(.PIX_W(PIX_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .line_end (line_end),
        .cnt_q_o  (cnt_q),
        .cnt_d_o  (cnt_d),
        .run_q_o  (run_q),
        .run_d_o  (run_d),
        .wrap_o   (wrap)
    );

    lpc_color_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_d    (run_d),
        .wrap     (wrap),
        .mode_all (mode_all),
        .col_q_o  (col_q),
        .col_d_o  (col_d)
    );

    for (genvar c = 0; c < NUM_COL; c++) begin : g_chan
        logic act_nxt;
        assign act_nxt = run_d && (mode_all || (col_d == color_e'(c)));
        lpc_lamp_chan #(.PIX_W(PIX_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .active_nxt (act_nxt),
            .cnt_nxt    (cnt_d),
            .on_at      (on_pos[c]),
            .off_at     (off_pos[c]),
            .lamp_o     (lamp[c])
        );
    end

    assign line_start = run_q && (cnt_q == '0);
    assign scan_sync  = line_start && (col_q == COL_RED);
    assign color_idx  = col_q;

    // R6: sequential mode lights at most one colour
    a_r6_single_colour: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_all |=> $onehot0(lamp));

    // R8: a scan may only start on a line start of a red line
    a_r8_sync_on_red: assert property (@(posedge clk) disable iff (!rst_n)
        scan_sync |-> (line_start && color_idx == 2'd0));

    // R9: standby darkens everything one edge later
    a_r9_dark: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (lamp == '0 && !line_start && !scan_sync && color_idx == 2'd0));

    // R4: a turn-on point past the line end is never reached
    a_r4_never_on: assert property (@(posedge clk) disable iff (!rst_n)
        (on_pos[0] > line_end && $stable(on_pos[0]) && $past(on_pos[0] > line_end) && !$past(lamp[0]))
            |-> !lamp[0]);

endmodule

// File: tb/lamp_pulse_ctrl_tb.sv
`timescale 1ns/1ps
module lamp_pulse_ctrl_tb;
    localparam int PIX_W = 12;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  standby = 1'b1;
    logic                  mode_all = 1'b0;
    logic [PIX_W-1:0]      line_end = '0;
    logic [2:0][PIX_W-1:0] on_pos = '0;
    logic [2:0][PIX_W-1:0] off_pos = '0;
    logic [2:0]            lamp;
    logic                  line_start, scan_sync;
    logic [1:0]            color_idx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lamp_pulse_ctrl #(.PIX_W(PIX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .mode_all(mode_all),
        .line_end(line_end), .on_pos(on_pos), .off_pos(off_pos),
        .lamp(lamp), .line_start(line_start), .scan_sync(scan_sync),
        .color_idx(color_idx)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic setup(input logic m, input int le,
                         input int o0, input int f0, input int o1, input int f1,
                         input int o2, input int f2);
        @(negedge clk);
        standby  = 1'b1;
        @(negedge clk);
        mode_all = m;
        line_end = PIX_W'(le);
        on_pos[0] = PIX_W'(o0); off_pos[0] = PIX_W'(f0);
        on_pos[1] = PIX_W'(o1); off_pos[1] = PIX_W'(f1);
        on_pos[2] = PIX_W'(o2); off_pos[2] = PIX_W'(f2);
    endtask

    // Releases standby and compares n cycles against pixel/line arithmetic.
    task automatic run_window(input int n, input string req);
        logic [2:0] exp_l = 3'b000;
        int le = int'(line_end);
        standby = 1'b0;
        for (int t = 0; t < n; t++) begin
            int p, ln, col;
            @(negedge clk);
            p   = t % (le + 1);
            ln  = t / (le + 1);
            col = mode_all ? 0 : ln % 3;
            for (int c = 0; c < 3; c++) begin
                if (!(mode_all || col == c)) exp_l[c] = 1'b0;
                else if (p == int'(on_pos[c])) exp_l[c] = 1'b1;
                else if (p == int'(off_pos[c])) exp_l[c] = 1'b0;
            end
            chk(req, "lamp", int'(lamp), int'(exp_l));
            chk("R1", "line_start", int'(line_start), int'(p == 0));
            chk("R2", "color_idx", int'(color_idx), col);
            chk("R8", "scan_sync", int'(scan_sync), int'(p == 0 && col == 0));
        end
    endtask

    task automatic t_reset;
        #1;
        chk("R10", "lamp", int'(lamp), 0);
        chk("R10", "line_start", int'(line_start), 0);
        chk("R10", "scan_sync", int'(scan_sync), 0);
        chk("R10", "color_idx", int'(color_idx), 0);
    endtask

    task automatic t_sequential;
        // R3 R6: one colour per line, last colour lit at pixel 0 and at line end
        setup(1'b0, 9, 2, 5, 3, 7, 0, 9);
        run_window(60, "R6");
    endtask

    task automatic t_all_colours;
        // R7: every colour pulses per line, with overlap and wrap-around pulse
        setup(1'b1, 9, 2, 5, 8, 3, 0, 9);
        run_window(40, "R7");
    endtask

    task automatic t_never_always;
        // R4 red past line end, R5 green off past line end, R3 blue equal points
        setup(1'b1, 7, 9, 3, 2, 12, 5, 5);
        run_window(32, "R5");
        chk("R4", "red dark", int'(lamp[0]), 0);
        chk("R5", "green lit", int'(lamp[1]), 1);
        chk("R3", "on wins", int'(lamp[2]), 1);
    endtask

    task automatic t_seq_corners;
        // R5 in sequential mode ends with the line; R3 turn-on on last pixel
        setup(1'b0, 5, 3, 9, 0, 0, 5, 2);
        run_window(36, "R5");
    endtask

    task automatic t_standby;
        setup(1'b1, 4, 0, 20, 1, 3, 9, 9);
        run_window(12, "R9");
        @(negedge clk);
        standby = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R9", "lamp", int'(lamp), 0);
            chk("R9", "line_start", int'(line_start), 0);
            chk("R9", "scan_sync", int'(scan_sync), 0);
            chk("R9", "color_idx", int'(color_idx), 0);
        end
        mode_all = 1'b0;
        run_window(30, "R9");
    endtask

    initial begin
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_sequential();
        t_all_colours();
        t_never_always();
        t_seq_corners();
        t_standby();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule